// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of 32 general-purpose pins behind a small 32-bit register port. Each pin has a direction bit and an output latch bit. The output latch is never written as a whole word. Software changes it by writing a mask to a set address or to a clear address. Every pin level passes through a two-flop synchronizer. The synchronized levels can be read back at any time, including on pins that are currently driving.

Each pin has a rising-edge enable and a falling-edge enable. Each enable mask is also changed only through its own set and clear addresses. The synchronized level is compared with its previous sample to find edges. An edge of an enabled polarity latches a bit in the interrupt status word. Software clears that bit by writing a one to it. Two interrupt request lines summarize the status word, one for pins 15..0 and one for pins 31..16.

The register port uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read returns its word on `rsp_valid` in the next cycle. The response is held until `rsp_ready` is seen high. While a response is stalled, `req_ready` stays low, so no further request is taken, whether it is a read or a write. Writes produce no response.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the direction word is all ones (`pin_oe` all zero) and the output latch is zero. Both edge-enable masks are zero, the status word is zero, and both interrupt lines are low.
- R2: The direction word is read and written at byte address 0x00. A bit of 1 makes the pin an input, with its `pin_oe` bit at 0. A bit of 0 makes it an output, with its `pin_oe` bit at 1.
- R3: Writing a mask to 0x08 sets the masked output-latch bits. Writing a mask to 0x0C clears them. Zero mask bits leave their latch bits unchanged, and `pin_out` carries the latch. Reads of 0x04 and 0x08 return the latch and a read of 0x0C returns zero. Writes to 0x04 and 0x10 have no effect.
- R4: A read of 0x10 returns the synchronized pin levels. A pin change driven just before clock edge k is returned by a read taken at edge k+2, and reads taken at edges k and k+1 still return the old level.
- R5: Writing ones to 0x14 / 0x18 sets / clears rising-edge enables, and writing ones to 0x1C / 0x20 sets / clears falling-edge enables. Zero bits have no effect. Reads of 0x14 and 0x1C return the two masks, and reads of 0x18 and 0x20 return zero.
- R6: A status bit at 0x24 is set only by an edge whose polarity is enabled on that pin. For a pin change driven just before edge k, the bit is set at edge k+2. An edge of a disabled polarity sets nothing.
- R7: Writing ones to 0x24 clears those status bits. Zero bits in that write have no effect.
- R8: If an enabled edge and a clear of the same status bit happen in the same cycle, the bit stays set.
- R9: `irq_lo` is the OR of status bits 15..0 and `irq_hi` is the OR of status bits 31..16.
- R10: A read response arrives on `rsp_valid` the cycle after acceptance. It holds `rsp_data` stable while `rsp_ready` is low. While it is stalled, `req_ready` is low and no request of any kind takes effect.
- R11: Edge detection works on pins configured as outputs too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address of the register |
| req_wdata | input | 32 | Write data or mask |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch toward the pads |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq_lo | output | 1 | Interrupt request for pins 15..0 |
| irq_hi | output | 1 | Interrupt request for pins 31..16 |

## Verification
Two functions can land in the same cycle: the latching of a detected edge and the write-one clear of that same status bit. The bench arms a rising enable on a pin whose status bit is already set. It raises the pin and times the clear write so that the write is taken on exactly the edge where the detector result is latched. It then reads the status word back and expects the bit still set. A second clear with no edge present is expected to empty the bit, which shows that the first result came from the edge winning and not from an ignored write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 6;
  localparam int SEL_W  = 4;

  // Word index of each register (byte address divided by four)
  typedef enum logic [SEL_W-1:0] {
    IDX_DIR  = 4'd0,
    IDX_OUT  = 4'd1,
    IDX_OSET = 4'd2,
    IDX_OCLR = 4'd3,
    IDX_IN   = 4'd4,
    IDX_RSET = 4'd5,
    IDX_RCLR = 4'd6,
    IDX_FSET = 4'd7,
    IDX_FCLR = 4'd8,
    IDX_STAT = 4'd9
  } reg_idx_e;

  localparam logic [SEL_W-1:0] SEL_NONE = 4'hF;

  typedef struct packed {
    logic dir;
    logic oset;
    logic oclr;
    logic rset;
    logic rclr;
    logic fset;
    logic fclr;
    logic sclr;
  } wr_hits_t;

  function automatic wr_hits_t decode_wr(input logic [SEL_W-1:0] sel);
    wr_hits_t h;
    h = '0;
    case (sel)
      IDX_DIR:  h.dir  = 1'b1;
      IDX_OSET: h.oset = 1'b1;
      IDX_OCLR: h.oclr = 1'b1;
      IDX_RSET: h.rset = 1'b1;
      IDX_RCLR: h.rclr = 1'b1;
      IDX_FSET: h.fset = 1'b1;
      IDX_FCLR: h.fclr = 1'b1;
      IDX_STAT: h.sclr = 1'b1;
      default:  h = '0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  // A reported rise must correspond to a level that is high now and was low a cycle earlier
  assert_rise_is_change_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise & $past(lvl)) == '0))
    else $error("rise reported on a pin that was already high");

endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output wr_hits_t          wr_hits,
  output logic [DW-1:0]     wr_data,
  output logic [SEL_W-1:0]  rd_sel,
  input  logic [DW-1:0]     rd_word
);

  logic              rsp_valid_q;
  logic [DW-1:0]     rsp_data_q;
  logic              accept;
  logic              aligned;
  logic [SEL_W-1:0]  sel;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign sel       = aligned ? req_addr[ADDR_W-1:2] : SEL_NONE;

  assign wr_hits = (accept && req_write) ? decode_wr(sel) : '0;
  assign wr_data = req_wdata;
  assign rd_sel  = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)))
    else $error("stalled response changed");

  assert_read_returns_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid)
    else $error("accepted read gave no response");

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_hits_t         wr_hits,
  input  logic [W-1:0]     wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [W-1:0]     rd_word,
  input  logic [W-1:0]     lvl,
  input  logic [W-1:0]     rise,
  input  logic [W-1:0]     fall,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic [1:0]       irq_half
);

  localparam int HALF = W / 2;

  logic [W-1:0] dir_q, out_q, ren_q, fen_q, stat_q;
  logic [W-1:0] set_o, clr_o, set_r, clr_r, set_f, clr_f, clr_s;
  logic [W-1:0] hits;

  assign set_o = wr_hits.oset ? wr_data : '0;
  assign clr_o = wr_hits.oclr ? wr_data : '0;
  assign set_r = wr_hits.rset ? wr_data : '0;
  assign clr_r = wr_hits.rclr ? wr_data : '0;
  assign set_f = wr_hits.fset ? wr_data : '0;
  assign clr_f = wr_hits.fclr ? wr_data : '0;
  assign clr_s = wr_hits.sclr ? wr_data : '0;

  assign hits = (rise & ren_q) | (fall & fen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_hits.dir) dir_q <= wr_data;
      out_q  <= (out_q | set_o) & ~clr_o;
      ren_q  <= (ren_q | set_r) & ~clr_r;
      fen_q  <= (fen_q | set_f) & ~clr_f;
      // a fresh edge outranks a clear on the same bit
      stat_q <= (stat_q & ~clr_s) | hits;
    end
  end

  always_comb begin
    case (rd_sel)
      IDX_DIR:  rd_word = dir_q;
      IDX_OUT:  rd_word = out_q;
      IDX_OSET: rd_word = out_q;
      IDX_IN:   rd_word = lvl;
      IDX_RSET: rd_word = ren_q;
      IDX_FSET: rd_word = fen_q;
      IDX_STAT: rd_word = stat_q;
      default:  rd_word = '0;
    endcase
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign irq_half[h] = |stat_q[h*HALF +: HALF];
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_hits.sclr |=> ((stat_q & $past(stat_q)) == $past(stat_q)))
    else $error("status bit dropped without a clear write");

  assert_stat_needs_edge_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(rise | fall)) == '0))
    else $error("status bit set without any edge");

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    wr_hits.sclr |=> ((stat_q & $past((rise & ren_q) | (fall & fen_q))) == $past((rise & ren_q) | (fall & fen_q))))
    else $error("clear beat a simultaneous edge");

  assert_oset_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hits.oset |=> ((pin_out & $past(wr_data)) == $past(wr_data)))
    else $error("set mask not applied to output latch");

  assert_oclr_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hits.oclr |=> ((pin_out & $past(wr_data)) == '0))
    else $error("clear mask not applied to output latch");

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NPINS-1:0]  rsp_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  wr_hits_t         wr_hits;
  logic [NPINS-1:0] wr_data;
  logic [SEL_W-1:0] rd_sel;
  logic [NPINS-1:0] rd_word;
  logic [NPINS-1:0] lvl, rise, fall;
  logic [1:0]       irq_half;

  gpio_bus_port #(.DW(NPINS)) u_port (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_hits(wr_hits), .wr_data(wr_data), .rd_sel(rd_sel), .rd_word(rd_word)
  );

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(lvl)
  );

  gpio_edge_det #(.W(NPINS)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_hits(wr_hits), .wr_data(wr_data), .rd_sel(rd_sel), .rd_word(rd_word),
    .lvl(lvl), .rise(rise), .fall(fall),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_half(irq_half)
  );

  assign irq_lo = irq_half[0];
  assign irq_hi = irq_half[1];

  // A stalled response blocks every request, so no write may land
  assert_stall_blocks_write_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> $stable(pin_out) && $stable(pin_oe))
    else $error("register changed while response stalled");

endmodule

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;

  localparam logic [5:0] A_DIR = 6'h00, A_OUT = 6'h04, A_OSET = 6'h08, A_OCLR = 6'h0C,
                         A_IN = 6'h10, A_RSET = 6'h14, A_RCLR = 6'h18, A_FSET = 6'h1C,
                         A_FCLR = 6'h20, A_STAT = 6'h24;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [5:0] req_addr = '0;
  logic [31:0] req_wdata = '0, pin_in = '0;
  logic req_ready, rsp_valid, irq_lo, irq_hi;
  logic [31:0] rsp_data, pin_out, pin_oe;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_edge_bank dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_data;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp_out, exp_r, exp_f, d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 32'h0);
    bus_rd(A_DIR, rd);  chk("R1 dir", rd, 32'hFFFF_FFFF);
    bus_rd(A_RSET, rd); chk("R1 rise enables", rd, 32'h0);
    bus_rd(A_FSET, rd); chk("R1 fall enables", rd, 32'h0);
    bus_rd(A_STAT, rd); chk("R1 status", rd, 32'h0);

    // R2 direction
    for (int k = 0; k < 8; k++) begin
      logic [31:0] d;
      d = 32'h1357_9BDF * (k + 1) ^ (32'h1 << (k * 4));
      bus_wr(A_DIR, d);
      bus_rd(A_DIR, rd);
      chk("R2 dir readback", rd, d);
      chk("R2 pin_oe", pin_oe, ~d);
    end
    bus_wr(A_DIR, 32'hFFFF_FFFF);

    // R3 output latch through set and clear masks
    exp_out = '0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] sm, cm;
      sm = 32'h1111_1111 * k;
      cm = 32'h0F0F_0F0F >> (k % 5);
      bus_wr(A_OSET, sm); exp_out = exp_out | sm;
      chk("R3 pin_out after set", pin_out, exp_out);
      bus_wr(A_OCLR, cm); exp_out = exp_out & ~cm;
      chk("R3 pin_out after clear", pin_out, exp_out);
    end
    bus_wr(A_OUT, ~exp_out);
    bus_wr(A_IN, 32'hFFFF_FFFF);
    chk("R3 write to 0x04/0x10 ignored", pin_out, exp_out);
    bus_rd(A_OUT, rd);  chk("R3 read 0x04", rd, exp_out);
    bus_rd(A_OSET, rd); chk("R3 read 0x08", rd, exp_out);
    bus_rd(A_OCLR, rd); chk("R3 read 0x0C", rd, 32'h0);

    // R4 synchronizer latency
    pin_in = 32'h1234_5678;
    bus_rd(A_IN, rd); chk("R4 read at edge k", rd, 32'h0);
    bus_rd(A_IN, rd); chk("R4 read at edge k+1", rd, 32'h0);
    bus_rd(A_IN, rd); chk("R4 read at edge k+2", rd, 32'h1234_5678);
    pin_in = 32'h0;
    settle();

    // R5 enable masks
    exp_r = '0; exp_f = '0;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] m;
      m = 32'hA5C3_0F96 >> k;
      bus_wr(A_RSET, m);      exp_r = exp_r | m;
      bus_wr(A_FCLR, m);      exp_f = exp_f & ~m;
      bus_wr(A_FSET, ~m);     exp_f = exp_f | ~m;
      bus_wr(A_RCLR, m << 3); exp_r = exp_r & ~(m << 3);
      bus_rd(A_RSET, rd); chk("R5 rise mask", rd, exp_r);
      bus_rd(A_FSET, rd); chk("R5 fall mask", rd, exp_f);
    end
    bus_rd(A_RCLR, rd); chk("R5 read 0x18", rd, 32'h0);
    bus_rd(A_FCLR, rd); chk("R5 read 0x20", rd, 32'h0);

    // R6 / R7 / R9 per-pin sweep
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      bus_wr(A_RCLR, 32'hFFFF_FFFF);
      bus_wr(A_FCLR, 32'hFFFF_FFFF);
      bus_wr(A_STAT, 32'hFFFF_FFFF);
      bus_wr(A_RSET, b);
      pin_in[i] = 1'b1;
      settle();
      chk("R9 irq_lo", {31'd0, irq_lo}, {31'd0, (i < 16)});
      chk("R9 irq_hi", {31'd0, irq_hi}, {31'd0, (i >= 16)});
      bus_rd(A_STAT, rd); chk("R6 rise latched", rd, b);
      bus_wr(A_STAT, b);
      pin_in[i] = 1'b0;
      settle();
      bus_rd(A_STAT, rd); chk("R6 fall ignored when disabled", rd, 32'h0);
      bus_wr(A_RCLR, b);
      bus_wr(A_FSET, b);
      pin_in[i] = 1'b1;
      settle();
      bus_rd(A_STAT, rd); chk("R6 rise ignored when disabled", rd, 32'h0);
      pin_in[i] = 1'b0;
      settle();
      bus_rd(A_STAT, rd); chk("R6 fall latched", rd, b);
      bus_wr(A_STAT, 32'h0);
      bus_wr(A_STAT, ~b);
      bus_rd(A_STAT, rd); chk("R7 zero bits keep status", rd, b);
      bus_wr(A_STAT, b);
      bus_rd(A_STAT, rd); chk("R7 one bit clears status", rd, 32'h0);
      chk("R9 irq idle", {30'd0, irq_hi, irq_lo}, 32'h0);
    end

    // R8 edge and clear in the same cycle
    bus_wr(A_FCLR, 32'hFFFF_FFFF);
    bus_wr(A_RSET, 32'h8);
    pin_in[3] = 1'b1;
    settle();
    pin_in[3] = 1'b0;
    settle();
    bus_rd(A_STAT, rd); chk("R8 precondition", rd, 32'h8);
    pin_in[3] = 1'b1;          // before edge k
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_wr(A_STAT, 32'h8);     // taken at edge k+2, same edge as the latch
    bus_rd(A_STAT, rd); chk("R8 edge wins over clear", rd, 32'h8);
    bus_wr(A_STAT, 32'h8);
    bus_rd(A_STAT, rd); chk("R8 plain clear", rd, 32'h0);

    // R11 detector on an output pin
    bus_wr(A_RCLR, 32'hFFFF_FFFF);
    bus_wr(A_DIR, ~32'h20);
    chk("R11 pin 5 drives", pin_oe, 32'h20);
    bus_wr(A_FSET, 32'h20);
    pin_in[5] = 1'b1;
    settle();
    pin_in[5] = 1'b0;
    settle();
    bus_rd(A_STAT, rd); chk("R11 edge on output pin", rd, 32'h20);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_wr(A_DIR, 32'hFFFF_FFFF);

    // R10 back-pressure
    bus_wr(A_OCLR, 32'hFFFF_FFFF);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_DIR;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R10 response raised", {31'd0, rsp_valid}, 32'd1);
    d0 = rsp_data;
    chk("R10 response data", d0, 32'hFFFF_FFFF);
    req_valid = 1'b1; req_write = 1'b1; req_addr = A_OSET; req_wdata = 32'h1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held valid", {31'd0, rsp_valid}, 32'd1);
      chk("R10 held data", rsp_data, d0);
      chk("R10 ready low", {31'd0, req_ready}, 32'd0);
      chk("R10 write blocked", pin_out, 32'h0);
    end
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R10 response drained", {31'd0, rsp_valid}, 32'd0);
    chk("R10 write taken after drain", pin_out, 32'h1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule